// File: doc/BRIEF.md
# Transmit Byte-Repetition Rate Adapter

This block sits on the transmit side between a MAC that presents one byte per beat, and a downstream core. The core is clocked at a fixed 125 MHz and always behaves as a 1 Gbps path. To carry the slower line rates, each MAC byte has to reach the core several times in a row: once at 1 Gbps, ten times at 100 Mbps and one hundred times at 10 Mbps. The adapter makes those copies by capturing the MAC byte, together with its enable and error flags, on a pacing strobe. It then holds the captured beat on the core side until the next strobe arrives.

An external generator produces the pacing strobe. At 100 Mbps it pulses once every ten core cycles, and at 10 Mbps once every hundred. At 1 Gbps the adapter ignores the strobe and takes a new beat on every cycle. A frame can only begin on a strobe, so the first byte of a frame is never shortened. The path has a fixed latency of one register.

Top module: `tx_rate_adapter`

## Requirements
- R1: A synchronous, active-high reset sets core_txd, core_txen and core_txer to zero at the next rising edge, even when a strobe is present.
- R2: With speed_sel = 2'b10 (1 Gbps), a beat is captured on every cycle whatever the value of pace_ce, so the outputs always equal the inputs of the previous cycle.
- R3: With speed_sel = 2'b01 (100 Mbps) or 2'b00 (10 Mbps), a beat is captured only on cycles where pace_ce is 1. Inputs on all other cycles have no effect on the outputs.
- R4: A captured beat appears on the outputs after exactly one rising edge.
- R5: The outputs hold unchanged between captures. With pace_ce pulsing every 10 cycles, each byte appears on 10 consecutive cycles. With pace_ce pulsing every 100 cycles, each byte appears on 100 consecutive cycles.
- R6: The enable and error flags share one register with their data byte, so all three outputs change on the same edge and are repeated the same number of times.
- R7: core_txen rises only in the cycle after a capture. When mac_txen rises between strobes, the rise does not reach the core until the next strobe.
- R8: The reserved code speed_sel = 2'b11 behaves as 10 Mbps (paced by pace_ce).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz core clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_sel | input | 2 | 00 = 10 Mbps, 01 = 100 Mbps, 10 = 1 Gbps, 11 = treated as 10 Mbps |
| pace_ce | input | 1 | Pacing strobe from the external enable generator |
| mac_txd | input | 8 | Transmit byte from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_txer | input | 1 | Transmit error from the MAC |
| core_txd | output | 8 | Repeated transmit byte to the core |
| core_txen | output | 1 | Repeated transmit enable to the core |
| core_txer | output | 1 | Repeated transmit error to the core |

## Verification
The assertions check the following on every cycle:
- reset clears the outputs;
- outputs hold between captures;
- a captured beat reaches the outputs one edge later;
- non-strobe inputs are ignored at the paced speeds;
- the 1 Gbps path passes beats through;
- every rise of core_txen follows a capture.

The exact run lengths of 10 and 100 copies depend on the cadence of the external strobe. Only the bench's scenarios can show them, by counting identical output beats while a correct pacing strobe is driven. The same applies to the delayed start of a frame whose enable rises between strobes, and to the handling of the reserved speed code.

// File: rtl/tx_ra_pkg.sv
package tx_ra_pkg;

    parameter int unsigned TX_DW = 8;

    typedef enum logic [1:0] {
        SPD_10M  = 2'b00,
        SPD_100M = 2'b01,
        SPD_1G   = 2'b10,
        SPD_RSV  = 2'b11
    } spd_t;

    typedef struct packed {
        logic [TX_DW-1:0] d;
        logic             en;
        logic             er;
    } tx_beat_t;

    // Paced speeds take a beat only on the strobe; the reserved code paces too.
    function automatic logic spd_is_paced(spd_t s);
        return (s != SPD_1G);
    endfunction

    // Nominal copies per byte at each speed.
    function automatic int unsigned spd_copies(spd_t s);
        case (s)
            SPD_1G:   return 1;
            SPD_100M: return 10;
            default:  return 100;
        endcase
    endfunction

endpackage

// File: rtl/tx_ra_qualify.sv
module tx_ra_qualify
    import tx_ra_pkg::*;
(
    input  spd_t speed,
    input  logic ce,
    output logic take
);

    always_comb begin
        if (spd_is_paced(speed)) take = ce;
        else                     take = 1'b1;
    end

endmodule

// File: rtl/tx_ra_hold.sv
module tx_ra_hold
    import tx_ra_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  tx_beat_t d,
    output tx_beat_t q
);

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (take) q <= d;
    end

    // R1: reset clears the held beat on the following edge
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (q == '0));

    // R4: a captured beat shows up after exactly one edge
    a_r4_one_edge: assert property (@(posedge clk) disable iff (rst)
        take |=> (q == $past(d)));

    // R5 / R6: without a capture the whole beat (data and flags) stays put
    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(q));

endmodule

// File: rtl/tx_rate_adapter.sv
module tx_rate_adapter
    import tx_ra_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       speed_sel,
    input  logic             pace_ce,
    input  logic [TX_DW-1:0] mac_txd,
    input  logic             mac_txen,
    input  logic             mac_txer,
    output logic [TX_DW-1:0] core_txd,
    output logic             core_txen,
    output logic             core_txer
);

    spd_t     speed;
    logic     take;
    tx_beat_t beat_in;
    tx_beat_t beat_out;

    assign speed = spd_t'(speed_sel);

    always_comb begin
        beat_in.d  = mac_txd;
        beat_in.en = mac_txen;
        beat_in.er = mac_txer;
    end

    tx_ra_qualify u_qualify (
        .speed (speed),
        .ce    (pace_ce),
        .take  (take)
    );

    tx_ra_hold u_hold (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .d    (beat_in),
        .q    (beat_out)
    );

    assign core_txd  = beat_out.d;
    assign core_txen = beat_out.en;
    assign core_txer = beat_out.er;

    // R2: at 1 Gbps the port outputs follow the port inputs one cycle later
    a_r2_gig_passthru: assert property (@(posedge clk) disable iff (rst)
        (speed_sel == 2'b10) |=>
            (core_txd == $past(mac_txd) && core_txen == $past(mac_txen)
             && core_txer == $past(mac_txer)));

    // R3 / R8: at paced speeds a cycle without strobe leaves the outputs alone
    a_r3_ignore_unpaced: assert property (@(posedge clk) disable iff (rst)
        (speed_sel != 2'b10 && !pace_ce) |=>
            ($stable(core_txd) && $stable(core_txen) && $stable(core_txer)));

    // R7: a frame start on the core side always follows a capture
    a_r7_frame_start: assert property (@(posedge clk) disable iff (rst)
        $rose(core_txen) |-> $past(take));

endmodule

// File: tb/tx_rate_adapter_tb.sv
module tx_rate_adapter_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] speed_sel;
    logic       pace_ce;
    logic [7:0] mac_txd;
    logic       mac_txen;
    logic       mac_txer;
    logic [7:0] core_txd;
    logic       core_txen;
    logic       core_txer;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tx_rate_adapter u_dut (
        .clk       (clk),
        .rst       (rst),
        .speed_sel (speed_sel),
        .pace_ce   (pace_ce),
        .mac_txd   (mac_txd),
        .mac_txen  (mac_txen),
        .mac_txer  (mac_txer),
        .core_txd  (core_txd),
        .core_txen (core_txen),
        .core_txer (core_txer)
    );

    function automatic logic [9:0] outs();
        return {core_txd, core_txen, core_txer};
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic ce, input logic [7:0] d, input logic en, input logic er);
        pace_ce  = ce;
        mac_txd  = d;
        mac_txen = en;
        mac_txer = er;
    endtask

    // R1: power-up reset, then reset while a strobed beat is offered
    task automatic t_reset();
        rst = 1'b1;
        speed_sel = 2'b10;
        drive(1'b1, 8'hFF, 1'b1, 1'b1);
        step();
        check("R1 reset state", outs(), 10'h000);
        step();
        check("R1 reset held", outs(), 10'h000);
        rst = 1'b0;
        step();
        check("R1 release passes beat", outs(), {8'hFF, 1'b1, 1'b1});
        rst = 1'b1;
        step();
        check("R1 mid-frame reset wins", outs(), 10'h000);
        rst = 1'b0;
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        step();
    endtask

    // R2 / R4: 1 Gbps pass-through with the strobe held low
    task automatic t_gig();
        speed_sel = 2'b10;
        for (int c = 0; c < 16; c++) begin
            logic [7:0] d;
            d = 8'(c * 7 + 3);
            drive(1'b0, d, c[0], c[1]);
            step();
            check("R2 R4 gig pass-through", outs(), {d, c[0], c[1]});
        end
        drive(1'b0, 8'h00, 1'b0, 1'b0);
        step();
    endtask

    // R3 / R5 / R6 / R8: paced run with garbage between strobes
    task automatic t_paced(input logic [1:0] spd, input int reps, input int nbytes, input string req);
        logic [9:0] exp;
        logic [9:0] prev;
        int run;
        int edges;
        speed_sel = spd;
        exp = outs();
        prev = outs();
        run = 0;
        edges = 0;
        for (int b = 0; b <= nbytes; b++) begin
            for (int j = 0; j < reps; j++) begin
                logic [7:0] d;
                logic en;
                logic er;
                if (b < nbytes) begin
                    d  = 8'(8'h10 + b);
                    en = 1'b1;
                    er = b[0];
                end else begin
                    d  = 8'h00;
                    en = 1'b0;
                    er = 1'b0;
                end
                if (j == 0) begin
                    drive(1'b1, d, en, er);
                    exp = {d, en, er};
                end else begin
                    drive(1'b0, ~d, ~en, ~er);
                end
                step();
                check({req, " R3 R6 held beat"}, outs(), exp);
                if (outs() == prev) begin
                    run++;
                end else begin
                    if (edges > 0) check_int({req, " R5 copies per byte"}, run, reps);
                    edges++;
                    run = 1;
                    prev = outs();
                end
            end
        end
        check_int({req, " R5 byte changes"}, edges, nbytes + 1);
        drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    // R7: enable rises between strobes and is delayed to the next strobe
    task automatic t_align();
        speed_sel = 2'b01;
        for (int c = 0; c < 20; c++) begin
            drive((c % 10) == 0, 8'hA5, c >= 4, 1'b0);
            step();
            check("R7 frame start waits for strobe", {9'h000, core_txen}, {9'h000, c >= 10});
        end
        drive(1'b1, 8'h00, 1'b0, 1'b0);
        step();
        drive(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_gig();
        t_paced(2'b01, 10, 6, "R5 100M");
        t_paced(2'b00, 100, 3, "R5 10M");
        t_paced(2'b11, 100, 2, "R8 reserved");
        t_align();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule